// File: doc/BRIEF.md
# Pulse-Counting Signed Multiply-Accumulate Element

This block forms a signed product without an array multiplier. Each operand pair starts a count window whose length depends on the input magnitude. A rate generator, programmed by the weight magnitude, emits count ticks during that window. An up/down counter accumulates the ticks. The number of ticks in one window is exactly the product of the two magnitudes. The sign relation of the two operands selects whether the counter goes up or down. The energy spent on an operation therefore grows with the size of its operands, and a zero operand costs no ticks.

The surrounding logic offers one operand pair at a time with a start strobe. It waits while the busy flag is high, and it sees a one-cycle done pulse when the window has closed. At that point the running signed total on the accumulator output is final. A synchronous clear returns the total to zero between or during operations.

Both operands are sign-magnitude coded: the top bit is the sign (1 means negative) and the remaining bits are the magnitude. The window lasts the input magnitude times 2^PHASE_W base cycles. In every base cycle, the rate generator adds the weight magnitude to a PHASE_W-bit phase and fires a tick when the phase overflows. The phase restarts from zero with each operation.

Top module: `tdmac_unit`

## Requirements
- R1: After reset the accumulator reads 0 and busy and done are both low.
- R2: An operand pair is taken only in a cycle where start is high and busy is low. A start seen while busy is high is ignored and does not change that operation's result or its window length.
- R3: After an operand pair is taken, busy is high for exactly |in| × 2^PHASE_W cycles, starting in the cycle after acceptance. The input magnitude is in_val bits [IN_W-2:0].
- R4: Done is high for exactly one cycle, in the first cycle with busy low after the window. When the input magnitude is zero, done is high in the cycle after acceptance and busy never rises.
- R5: A completed operation changes the accumulator by exactly |in| × |wt|. It counts up when the sign bits (bit IN_W-1 of in_val and bit WT_W-1 of wt_val) are equal and counts down when they differ.
- R6: An input magnitude of zero or a weight magnitude of zero, including a negative zero, leaves the accumulator unchanged.
- R7: The accumulator moves by at most one per cycle, and it moves only in the cycle after one in which busy or clr was high.
- R8: The accumulator saturates at 2^(ACC_W-1)-1 and at -2^(ACC_W-1) and never wraps.
- R9: A clr reads back as 0 one cycle later. A clr takes priority over a count tick that falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous accumulator clear |
| start | input | 1 | Offer an operand pair |
| in_val | input | IN_W | Sign-magnitude input operand |
| wt_val | input | WT_W | Sign-magnitude weight operand |
| busy | output | 1 | Count window open |
| done | output | 1 | One-cycle pulse when the window closes |
| acc | output | ACC_W | Signed two's-complement running total |

## Verification
The bench builds the block with ACC_W of 12 and PHASE_W of 5. It keeps the 6-bit operands. The narrow accumulator lets a few full-scale products of 961 drive the total into both saturation limits within a short run. The shorter phase keeps each window at 32 cycles per unit of input magnitude, so the busy length and the exact tick count can still be checked for every pair. The window length and the tick total stay exact for these values, because the 5-bit weight magnitude still fits the 5-bit phase.

// File: rtl/tdmac_pkg.sv
// Package: shared types for the pulse-counting MAC element.
// Assumes nothing beyond IEEE 1800-2017.
package tdmac_pkg;

    // Count direction applied to the accumulator on each tick.
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

endpackage

// File: rtl/tdmac_pulse_gen.sv
// Module: tdmac_pulse_gen
// Opens a count window of mag * 2^PHASE_W cycles on load.
// It raises done for one cycle after the window closes.
// A zero magnitude gives no window and an immediate done.
// Assumes load is only raised while active is low.
module tdmac_pulse_gen #(
    parameter int MAG_W   = 5,
    parameter int PHASE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [MAG_W-1:0] mag,
    output logic             active,
    output logic             done
);
    localparam int CNT_W = MAG_W + PHASE_W;

    logic [CNT_W-1:0] remain_q;
    logic             active_q;
    logic             done_q;

    // Window counter: load the length, count down, and flag the close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            active_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                if (mag == '0) begin
                    done_q <= 1'b1;
                end else begin
                    active_q <= 1'b1;
                    remain_q <= {mag, {PHASE_W{1'b0}}};
                end
            end else if (active_q) begin
                if (remain_q == CNT_W'(1)) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end
                remain_q <= remain_q - CNT_W'(1);
            end
        end
    end

    assign active = active_q;
    assign done   = done_q;

endmodule

// File: rtl/tdmac_rate_gen.sv
// Module: tdmac_rate_gen
// Phase accumulator that stands in for a weight-controlled oscillator.
// While enabled it adds rate to a PHASE_W-bit phase each cycle.
// Each overflow is one tick, so it gives rate ticks per 2^PHASE_W cycles.
// Assumes RATE_W <= PHASE_W. Restart zeroes the phase.
module tdmac_rate_gen #(
    parameter int RATE_W  = 5,
    parameter int PHASE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              enable,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W:0]   sum;

    // Next phase with its carry, which marks a tick.
    always_comb begin
        sum = {1'b0, phase_q} + (PHASE_W + 1)'(rate);
    end

    // Phase register: cleared on restart, advanced while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase_q <= '0;
        end else if (enable) begin
            phase_q <= sum[PHASE_W-1:0];
        end
    end

    assign tick = enable & sum[PHASE_W];

endmodule

// File: rtl/tdmac_updown_acc.sv
// Module: tdmac_updown_acc
// Signed saturating up/down counter that moves by one per step.
// Clear has priority over step. Assumes ACC_W >= 2.
module tdmac_updown_acc
    import tdmac_pkg::*;
#(
    parameter int ACC_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  cnt_dir_e         dir,
    output logic [ACC_W-1:0] acc
);
    localparam logic [ACC_W-1:0] TOP_V = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] BOT_V = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W-1:0] acc_q;

    // Count register: clear first, then a step that stops at either limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
        end else if (step) begin
            if (dir == DIR_UP && acc_q != TOP_V) begin
                acc_q <= acc_q + ACC_W'(1);
            end else if (dir == DIR_DOWN && acc_q != BOT_V) begin
                acc_q <= acc_q - ACC_W'(1);
            end
        end
    end

    assign acc = acc_q;

endmodule

// File: rtl/tdmac_unit.sv
// Module: tdmac_unit (top)
// Signed MAC built from a count window gated with a tick stream.
// Operands are sign-magnitude, with the MSB as the sign.
// Assumes WT_W-1 <= PHASE_W so the tick rate never exceeds one per cycle.
module tdmac_unit
    import tdmac_pkg::*;
#(
    parameter int IN_W    = 6,
    parameter int WT_W    = 6,
    parameter int ACC_W   = 21,
    parameter int PHASE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             start,
    input  logic [IN_W-1:0]  in_val,
    input  logic [WT_W-1:0]  wt_val,
    output logic             busy,
    output logic             done,
    output logic [ACC_W-1:0] acc
);
    localparam int IN_MAG_W = IN_W - 1;
    localparam int WT_MAG_W = WT_W - 1;

    logic                accept;
    logic                active;
    logic                tick;
    logic [WT_MAG_W-1:0] wt_mag_q;
    cnt_dir_e            dir_q;

    assign accept = start & ~active;

    // Operand capture: hold the weight magnitude and the count direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wt_mag_q <= '0;
            dir_q    <= DIR_UP;
        end else if (accept) begin
            wt_mag_q <= wt_val[WT_MAG_W-1:0];
            dir_q    <= cnt_dir_e'(in_val[IN_W-1] ^ wt_val[WT_W-1]);
        end
    end

    tdmac_pulse_gen #(
        .MAG_W  (IN_MAG_W),
        .PHASE_W(PHASE_W)
    ) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .mag   (in_val[IN_MAG_W-1:0]),
        .active(active),
        .done  (done)
    );

    tdmac_rate_gen #(
        .RATE_W (WT_MAG_W),
        .PHASE_W(PHASE_W)
    ) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(accept),
        .enable (active),
        .rate   (wt_mag_q),
        .tick   (tick)
    );

    tdmac_updown_acc #(
        .ACC_W(ACC_W)
    ) u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .step (tick),
        .dir  (dir_q),
        .acc  (acc)
    );

    assign busy = active;

endmodule

// File: rtl/tdmac_unit_chk.sv
// Module: tdmac_unit_chk
// Temporal checks on the ports of tdmac_unit, attached by bind.
module tdmac_unit_chk #(
    parameter int ACC_W = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [ACC_W-1:0] acc
);
    localparam logic signed [ACC_W:0] ONE_X = 1;

    logic signed [ACC_W:0] acc_x;
    assign acc_x = {acc[ACC_W-1], acc};

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !clr) |=> $stable(acc)); // R7

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr) |=> (acc_x == $past(acc_x) || acc_x == $past(acc_x) + ONE_X
                    || acc_x == $past(acc_x) - ONE_X)); // R8

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0)); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R4

    AST_BUSY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && $past(busy)) |-> !done); // R2

endmodule

bind tdmac_unit tdmac_unit_chk #(.ACC_W(ACC_W)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .start(start),
    .busy (busy),
    .done (done),
    .acc  (acc)
);

// File: tb/test_tdmac_unit.sv
module test_tdmac_unit;
    localparam int IN_W    = 6;
    localparam int WT_W    = 6;
    localparam int ACC_W   = 12;
    localparam int PHASE_W = 5;
    localparam int ACC_MAX = (1 << (ACC_W - 1)) - 1;
    localparam int ACC_MIN = -(1 << (ACC_W - 1));

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr = 1'b0;
    logic             start = 1'b0;
    logic [IN_W-1:0]  in_val = '0;
    logic [WT_W-1:0]  wt_val = '0;
    logic             busy;
    logic             done;
    logic [ACC_W-1:0] acc;

    int checks = 0;
    int fails  = 0;
    int model  = 0;
    int cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    tdmac_unit #(
        .IN_W(IN_W), .WT_W(WT_W), .ACC_W(ACC_W), .PHASE_W(PHASE_W)
    ) i_tdmac_unit (
        .clk(clk), .rst_n(rst_n), .clr(clr), .start(start),
        .in_val(in_val), .wt_val(wt_val), .busy(busy), .done(done), .acc(acc)
    );

    function automatic int mag_of(input logic [5:0] v);
        return int'(v[4:0]);
    endfunction

    function automatic int next_total(input int cur, input logic [5:0] a, input logic [5:0] w);
        int d = mag_of(a) * mag_of(w);
        int r = (a[5] ^ w[5]) ? cur - d : cur + d;
        if (r > ACC_MAX) r = ACC_MAX;
        if (r < ACC_MIN) r = ACC_MIN;
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int acc_int();
        return int'($signed(acc));
    endfunction

    // One operation. junk: keep offering other operands while busy (R2).
    // clr_last: pulse clr in the last busy cycle (R9 priority).
    task automatic run_op(input logic [5:0] a, input logic [5:0] w,
                          input bit junk, input bit clr_last);
        int cnt = 0;
        int len = mag_of(a) << PHASE_W;
        @(negedge clk);
        start = 1'b1; in_val = a; wt_val = w;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        while (busy && cnt < 4000) begin
            cnt++;
            clr = (clr_last && cnt == len) ? 1'b1 : 1'b0;
            if (junk) begin
                start = 1'b1; in_val = 6'h1F; wt_val = 6'h1F;
            end
            @(negedge clk);
        end
        start = 1'b0; clr = 1'b0;
        model = clr_last ? 0 : next_total(model, a, w);
        check("R3 busy length", cnt, len);
        check("R4 done after window", int'(done), 1);
        check("R5 accumulated total", acc_int(), model);
        @(negedge clk);
        check("R4 done single", int'(done), 0);
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 acc reset", acc_int(), 0);
        check("R1 busy reset", int'(busy), 0);
        check("R1 done reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 directed signs
        run_op(6'h03, 6'h05, 0, 0);   // +15
        run_op(6'h22, 6'h04, 0, 0);   // -8
        run_op(6'h02, 6'h23, 0, 0);   // -6
        run_op(6'h21, 6'h27, 0, 0);   // +7

        // R6 zero operands, R4 zero-length window
        run_op(6'h05, 6'h00, 0, 0);
        run_op(6'h04, 6'h20, 0, 0);
        @(negedge clk);
        start = 1'b1; in_val = 6'h20; wt_val = 6'h1F;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R4 zero input done", int'(done), 1);
        check("R6 zero input busy", int'(busy), 0);
        check("R6 zero input acc", acc_int(), model);
        @(negedge clk);
        check("R6 zero input acc later", acc_int(), model);

        // R2 start while busy ignored
        run_op(6'h02, 6'h03, 1, 0);

        // R9 clear, standalone and on the final tick
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0; model = 0;
        check("R9 clear", acc_int(), 0);
        run_op(6'h03, 6'h05, 0, 0);
        run_op(6'h01, 6'h1F, 0, 1);
        check("R9 clear beats tick", acc_int(), 0);

        // R8 saturation both ways
        repeat (3) run_op(6'h1F, 6'h1F, 0, 0);
        check("R8 top limit", acc_int(), ACC_MAX);
        run_op(6'h01, 6'h01, 0, 0);
        check("R8 holds at top", acc_int(), ACC_MAX);
        repeat (5) run_op(6'h3F, 6'h1F, 0, 0);
        check("R8 bottom limit", acc_int(), ACC_MIN);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0; model = 0;

        // R5 random pairs
        for (int i = 0; i < 40; i++) begin
            logic [5:0] a = 6'($urandom);
            logic [5:0] w = 6'($urandom);
            run_op(a, w, 1'($urandom % 2), 0);
        end

        // R7 idle stability
        repeat (10) @(negedge clk);
        check("R7 idle hold", acc_int(), model);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule